// File: doc/BRIEF.md
# Time-of-Day Alarm Match Unit

This unit holds three alarm registers, one each for seconds, minutes and hours, in packed BCD. It watches the running time delivered by a separate timekeeping counter. The counter asserts a one-cycle `time_tick` whenever it presents a new time value. On that cycle the unit compares the stored alarm against the current time. When all three fields agree, it raises a sticky alarm flag and a one-cycle event pulse for the downstream interrupt logic.

Bit 7 of every alarm register is a wildcard control. On the minutes and hours registers, setting it makes that field match any value. On the seconds register, setting it makes the field match only on the tick that shows second 00, which is the 59-to-00 rollover. With all three wildcards set, the alarm therefore fires once a minute. The low seven bits of each register use the same layout as the corresponding time field. For hours this includes the 12/24-hour indicator in bit 6 and the AM/PM bit in bit 5, and both are compared.

Software reads and writes the registers through a simple select/strobe port. Any read or write of an alarm register clears the pending flag, so reading back the alarm time also acknowledges it.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, `tod_flag` and `tod_event` are 0 and all three alarm registers read 8'h00.
- R2: `reg_sel` picks the register: 0 is seconds, 1 is minutes, 2 is hours. A write stores all 8 bits of `reg_wdata`, and a read returns them combinationally on `reg_rdata`. `reg_sel` = 3 addresses no register and reads 8'h00.
- R3: A comparison happens only on a cycle with `time_tick` = 1. A full match on that cycle sets `tod_flag` and drives `tod_event` high for exactly the following cycle. Matching time without a tick does nothing.
- R4: When bit 7 is 0, a field matches only if bits 6:0 of the register equal the 7-bit current time field. For hours, bits 6 (12/24 indicator) and 5 (AM/PM) are part of the comparison.
- R5: When bit 7 of the minutes or hours register is 1, that field matches every value.
- R6: When bit 7 of the seconds register is 1, the seconds field matches only when `now_sec` = 7'h00. With all three bit-7 wildcards set, the alarm fires once per minute, on the 59-to-00 rollover.
- R7: A read or write with `reg_sel` 0 to 2 clears `tod_flag` at the next edge, unless R8 applies. An access with `reg_sel` = 3 leaves the flag untouched.
- R8: If an alarm-register access and a match on a tick fall in the same cycle, the match wins: `tod_flag` stays 1 and `tod_event` pulses.
- R9: `tod_flag` stays 1 until an access clears it. Further matches while it is set still pulse `tod_event`. The alarm registers keep their values after the alarm fires.
- R10: A write on a tick cycle takes effect after that cycle's comparison. That comparison uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access) |
| reg_sel | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours |
| reg_wdata | input | 8 | Write data, bit 7 is the wildcard control |
| reg_rdata | output | 8 | Read data for the selected register |
| time_tick | input | 1 | One-cycle strobe: a new time is on the `now_*` inputs |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hr | input | 7 | Current hours, BCD with 12/24 bit 6 and AM/PM bit 5 |
| tod_flag | output | 1 | Sticky alarm flag |
| tod_event | output | 1 | One-cycle pulse per alarm match |

## Verification
The bench targets these corner cases:

- **Access and match in the same cycle.** A design that lets the clear win would drop an alarm that software never saw.
- **Writes on a tick cycle.** A design that compares against the newly written value would fire, or stay silent, one tick early.
- **Seconds wildcard at second 59 and second 00.** A plain don't-care on seconds would fire on every tick instead of once a minute.
- **Hour values that differ only in the 12/24 bit.** A design that drops that bit from the comparison would match them.

Random stimulus then mixes ticks, time values aimed at the alarm, wildcard settings, and reads to the unused select value. The bench checks both outputs every cycle against its own model.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int REG_W      = 8;
  localparam int FIELD_W    = REG_W - 1;
  localparam int NUM_FIELDS = 3;
  localparam int SEL_W      = $clog2(NUM_FIELDS + 1);
  localparam int WILD_BIT   = REG_W - 1;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC = 2'd0,
    FLD_MIN = 2'd1,
    FLD_HR  = 2'd2
  } fld_e;

  typedef logic [NUM_FIELDS-1:0][REG_W-1:0]   alarm_bank_t;
  typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] time_bank_t;

  // Field comparison: a wildcard on the seconds field only accepts second 00.
  function automatic logic field_hit(input logic [REG_W-1:0]   alarm,
                                     input logic [FIELD_W-1:0] now,
                                     input logic               is_seconds);
    logic hit;
    if (alarm[WILD_BIT])
      hit = is_seconds ? (now == '0) : 1'b1;
    else
      hit = (alarm[FIELD_W-1:0] == now);
    return hit;
  endfunction
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output alarm_bank_t      alarm_q,
  output logic             access
);
  logic sel_ok;
  assign sel_ok = (sel < SEL_W'(NUM_FIELDS));
  assign access = (wr_en | rd_en) & sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= '0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (wr_en && sel == SEL_W'(i)) alarm_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (sel == SEL_W'(i)) rdata = alarm_q[i];
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_chk
    // R2: a write lands in the selected register at the next edge
    assert_write_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_W'(gi)) |=> (alarm_q[gi] == $past(wdata)));
    // R9: without a write to it, a register holds its value
    assert_reg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == SEL_W'(gi)) |=> $stable(alarm_q[gi]));
  end
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
  import tod_alarm_pkg::*;
(
  input  alarm_bank_t           alarm_q,
  input  time_bank_t            now,
  output logic [NUM_FIELDS-1:0] fld_hit,
  output logic                  all_hit
);
  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_fld
    assign fld_hit[gi] = field_hit(alarm_q[gi], now[gi], gi == int'(FLD_SEC));
  end
  assign all_hit = &fld_hit;
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic all_hit,
  input  logic access,
  output logic flag,
  output logic event_pulse
);
  logic fire;
  assign fire = tick & all_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag        <= 1'b0;
      event_pulse <= 1'b0;
    end else begin
      event_pulse <= fire;
      if (fire)        flag <= 1'b1;
      else if (access) flag <= 1'b0;
    end
  end

  // R3: a match on a tick produces the event on the next cycle
  assert_fire_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> event_pulse);
  // R3: no event without a tick one cycle before
  assert_event_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> $past(tick));
  // R7: an access with no concurrent match clears the flag
  assert_access_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !fire) |=> !flag);
  // R8: a match wins over a concurrent access
  assert_match_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && access) |=> (flag && event_pulse));
  // R9: the flag is sticky until an access
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !access) |=> flag);
  // R3: an event always comes with the flag
  assert_event_has_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> flag);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             time_tick,
  input  logic [FIELD_W-1:0] now_sec,
  input  logic [FIELD_W-1:0] now_min,
  input  logic [FIELD_W-1:0] now_hr,
  output logic             tod_flag,
  output logic             tod_event
);
  alarm_bank_t           alarm_q;
  time_bank_t            now_bank;
  logic [NUM_FIELDS-1:0] fld_hit;
  logic                  all_hit;
  logic                  reg_access;

  assign now_bank[FLD_SEC] = now_sec;
  assign now_bank[FLD_MIN] = now_min;
  assign now_bank[FLD_HR]  = now_hr;

  tod_alarm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .alarm_q (alarm_q),
    .access  (reg_access)
  );

  tod_alarm_cmp u_cmp (
    .alarm_q (alarm_q),
    .now     (now_bank),
    .fld_hit (fld_hit),
    .all_hit (all_hit)
  );

  tod_alarm_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (time_tick),
    .all_hit     (all_hit),
    .access      (reg_access),
    .flag        (tod_flag),
    .event_pulse (tod_event)
  );

  // R5: wildcard minutes and hours fields always agree
  assert_min_wild_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q[FLD_MIN][WILD_BIT] |-> fld_hit[FLD_MIN]);
  assert_hr_wild_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q[FLD_HR][WILD_BIT] |-> fld_hit[FLD_HR]);
  // R6: a wildcard seconds field agrees only at second 00
  assert_sec_rollover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q[FLD_SEC][WILD_BIT] && fld_hit[FLD_SEC]) |-> (now_sec == '0));
  // R4: an exact hours match includes the 12/24 and AM/PM bits
  assert_hr_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_q[FLD_HR][WILD_BIT] && fld_hit[FLD_HR]) |-> (now_hr == alarm_q[FLD_HR][FIELD_W-1:0]));
endmodule

// File: tb/tod_alarm_match_test.sv
`timescale 1ns/1ps
module tod_alarm_match_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, time_tick = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [6:0] now_sec = '0, now_min = '0, now_hr = '0;
  logic       tod_flag, tod_event;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_al [3];
  logic       m_flag;

  always #4 clk = ~clk;

  tod_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_tick(time_tick), .now_sec(now_sec), .now_min(now_min),
    .now_hr(now_hr), .tod_flag(tod_flag), .tod_event(tod_event)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Alarm decision stated from the requirements, field by field.
  function automatic bit want_alarm(input logic [7:0] as, input logic [7:0] am,
                                    input logic [7:0] ah, input logic [6:0] s,
                                    input logic [6:0] m, input logic [6:0] h);
    bit ok_s, ok_m, ok_h;
    ok_s = as[7] ? (s == 7'h00) : (as[6:0] == s);
    ok_m = am[7] || (am[6:0] == m);
    ok_h = ah[7] || (ah[6:0] == h);
    return ok_s && ok_m && ok_h;
  endfunction

  function automatic logic [6:0] rbcd(input int tens_max);
    int t, o;
    t = $urandom_range(tens_max, 0);
    o = $urandom_range(9, 0);
    return 7'(t * 16 + o);
  endfunction

  task automatic step(input string tag, input bit tk, input logic [6:0] s,
                      input logic [6:0] m, input logic [6:0] h, input bit wr,
                      input bit rd, input logic [1:0] sel, input logic [7:0] wd);
    bit hit, acc;
    logic [7:0] exp_rd;
    @(negedge clk);
    time_tick = tk; now_sec = s; now_min = m; now_hr = h;
    reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd;
    #1;
    exp_rd = (sel < 2'd3) ? m_al[sel] : 8'h00;
    if (rd) chk({tag, " rdata"}, reg_rdata, exp_rd);
    hit = tk && want_alarm(m_al[0], m_al[1], m_al[2], s, m, h);
    acc = (wr || rd) && (sel < 2'd3);
    @(posedge clk);
    #1;
    m_flag = hit ? 1'b1 : (acc ? 1'b0 : m_flag);
    chk({tag, " event"}, {7'b0, tod_event}, {7'b0, hit});
    chk({tag, " flag"}, {7'b0, tod_flag}, {7'b0, m_flag});
    if (wr && sel < 2'd3) m_al[sel] = wd;
  endtask

  task automatic wr_reg(input string tag, input logic [1:0] sel, input logic [7:0] v);
    step(tag, 0, 7'h00, 7'h00, 7'h00, 1, 0, sel, v);
  endtask

  task automatic rd_reg(input string tag, input logic [1:0] sel);
    step(tag, 0, 7'h00, 7'h00, 7'h00, 0, 1, sel, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected normal end");
    summary();
    $finish;
  end

  initial begin
    logic [6:0] s, m, h;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) m_al[i] = 8'h00;
    m_flag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 flag after reset", {7'b0, tod_flag}, 8'h00);
    chk("R1 event after reset", {7'b0, tod_event}, 8'h00);
    for (int i = 0; i < 4; i++) rd_reg("R1 reset readback", 2'(i));

    // R2: write and read back
    wr_reg("R2 write sec", 2'd0, 8'h30);
    wr_reg("R2 write min", 2'd1, 8'h15);
    wr_reg("R2 write hr", 2'd2, 8'h48);
    for (int i = 0; i < 4; i++) rd_reg("R2 readback", 2'(i));

    // R3: matching time without a tick does nothing
    step("R3 no tick", 0, 7'h30, 7'h15, 7'h48, 0, 0, 2'd0, 8'h00);
    // R4: hour differing only in the 12/24 bit does not match
    step("R4 12/24 bit differs", 1, 7'h30, 7'h15, 7'h08, 0, 0, 2'd0, 8'h00);
    step("R4 seconds off by one", 1, 7'h31, 7'h15, 7'h48, 0, 0, 2'd0, 8'h00);
    // R3: full match on tick
    step("R3 match on tick", 1, 7'h30, 7'h15, 7'h48, 0, 0, 2'd0, 8'h00);
    step("R9 flag holds, event drops", 0, 7'h31, 7'h15, 7'h48, 0, 0, 2'd0, 8'h00);
    // R7: access with reg_sel 3 does not clear
    rd_reg("R7 sel 3 no clear", 2'd3);
    // R9 + R7: readback after alarm shows stored value and clears
    rd_reg("R9 R7 read clears", 2'd0);

    // R5: wildcard minutes and hours
    wr_reg("R5 min wild", 2'd1, 8'h80);
    wr_reg("R5 hr wild", 2'd2, 8'h80);
    step("R5 any min/hr", 1, 7'h30, 7'h42, 7'h67, 0, 0, 2'd0, 8'h00);
    step("R5 second mismatch", 1, 7'h29, 7'h42, 7'h67, 0, 0, 2'd0, 8'h00);
    wr_reg("R7 write clears", 2'd1, 8'h80);

    // R6: wildcard seconds fire only at second 00
    wr_reg("R6 sec wild", 2'd0, 8'h80);
    step("R6 second 59", 1, 7'h59, 7'h10, 7'h11, 0, 0, 2'd0, 8'h00);
    step("R6 second 00", 1, 7'h00, 7'h11, 7'h11, 0, 0, 2'd0, 8'h00);
    step("R6 second 01", 1, 7'h01, 7'h11, 7'h11, 0, 0, 2'd0, 8'h00);

    // R8: access and match in the same cycle
    step("R8 access with match", 1, 7'h00, 7'h12, 7'h11, 0, 1, 2'd2, 8'h00);
    step("R8 flag kept", 0, 7'h01, 7'h12, 7'h11, 0, 0, 2'd0, 8'h00);
    rd_reg("R7 clear after R8", 2'd1);

    // R10: write on a tick cycle compares against the old value
    wr_reg("R10 setup sec", 2'd0, 8'h05);
    step("R10 old value used", 1, 7'h05, 7'h33, 7'h09, 1, 0, 2'd0, 8'h06);
    step("R10 new value now", 1, 7'h05, 7'h33, 7'h09, 0, 0, 2'd0, 8'h00);
    step("R10 new value hit", 1, 7'h06, 7'h33, 7'h09, 0, 0, 2'd0, 8'h00);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(99, 0);
      if (r < 8) begin
        int fs;
        logic [7:0] v;
        fs = $urandom_range(2, 0);
        if (fs == 2) v = {1'b0, $urandom_range(1, 0) == 1, rbcd(2)[5:0]};
        else         v = {1'b0, rbcd(5)};
        if ($urandom_range(3, 0) == 0) v[7] = 1'b1;
        step("R2 R10 random write", $urandom_range(1, 0) == 1, rbcd(5), rbcd(5),
             {$urandom_range(1, 0) == 1, rbcd(2)[5:0]}, 1, 0, 2'(fs), v);
      end else begin
        bit aim;
        aim = ($urandom_range(1, 0) == 1);
        s = rbcd(5); m = rbcd(5); h = {$urandom_range(1, 0) == 1, rbcd(2)[5:0]};
        if (aim) begin
          s = m_al[0][7] ? (($urandom_range(1, 0) == 1) ? 7'h00 : s) : m_al[0][6:0];
          m = m_al[1][7] ? m : m_al[1][6:0];
          h = m_al[2][7] ? h : m_al[2][6:0];
        end
        step("R3 R7 R8 random", $urandom_range(2, 0) != 0, s, m, h, 0,
             r > 90, 2'($urandom_range(3, 0)), 8'h00);
      end
    end

    summary();
    $finish;
  end
endmodule